// File: doc/BRIEF.md
# Dual-Bank Filter Coefficient Controller

This block is the host-facing control store of a nine-tap image or signal filter. A host drives a 3-bit address, an 8-bit data byte and a load strobe. The strobe may be asynchronous to the processing clock. The block brings the strobe into the clock domain and turns each rising edge into exactly one internal write, applied to the register that the address selects. It holds a 4-bit setup word and two banks of nine 8-bit coefficients, named A to I. One of the two banks is always active, and it drives all nine multiplier coefficient inputs of the datapath in parallel.

Each bank is loaded one byte per strobe, starting at A and stepping towards I. A load sequence begins again at A whenever a write to that bank follows a write to any other address. The host can refill the idle bank while the datapath runs on the active one, then switch banks with a single write. The switch, like every setup change, takes effect on one clock edge, so the datapath never sees a partly updated state and loses no processing cycle.

Top module: `coef_bank_ctrl`

## Requirements
- R1: After reset, bank 0 is active, every coefficient output is zero, and the format, mode and rounding outputs are zero.
- R2: A strobe with address 3'b010 stores the data byte in the next coefficient slot of bank 0, and address 3'b011 does the same for bank 1. The slots fill in order A, B, ... I, and slot k appears on `coef_active[8*k +: 8]` when its bank is active (A is k=0).
- R3: A write to a bank that follows a write to any other address, including reserved and no-op addresses, restarts that bank's fill at slot A. Slots not yet rewritten keep their values.
- R4: Once all nine slots of a bank have been written, further writes to that bank leave it unchanged until a restart.
- R5: A strobe with address 3'b100 loads data bits 3:0 into the setup word. Bit 0 drives `fmt_signed` (0 unsigned, 1 two's complement), bit 1 drives `mode_2d` (0 one-dimensional, 1 two-dimensional) and bits 3:2 drive `round_sel`.
- R6: A strobe with address 3'b101 makes bank 0 active and address 3'b110 makes bank 1 active. The whole nine-coefficient output follows the active bank.
- R7: Strobes with addresses 3'b000, 3'b001 and 3'b111 change no output.
- R8: A strobe held high for many clock cycles produces exactly one write.
- R9: A write becomes visible on the outputs after the third rising clock edge that samples the strobe high, and not after the second.
- R10: Writes to the inactive bank do not change `coef_active` or `active_bank`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 3 | Target register or command, held stable while the strobe is high |
| host_data | input | 8 | Coefficient or setup byte |
| host_ld | input | 1 | Host load strobe, asynchronous; its rising edge triggers one write |
| coef_active | output | 72 | Nine coefficients of the active bank, slot k at bits 8k+7:8k |
| active_bank | output | 1 | Index of the active bank |
| fmt_signed | output | 1 | Data and coefficient format, 1 means two's complement |
| mode_2d | output | 1 | Filter mode, 1 means 3x3 two-dimensional |
| round_sel | output | 2 | Output rounding selection |

## Verification
The bench fills both banks with distinct byte patterns, so that a slot written to the wrong position or the wrong bank shows up as a mismatch on the active output. Partial reloads interrupted by a no-op show whether the fill restarts at A and keeps the untouched slots. An overflow write after slot I shows whether a tenth byte is dropped. A strobe held for twenty cycles, followed by a second write, tells a single write apart from a repeated one. A bank switch sampled right after the second and the third clock edges pins down the latency.

// File: rtl/cbc_pkg.sv
`timescale 1ns/1ps
package cbc_pkg;

    typedef enum logic [2:0] {
        OP_RSVD      = 3'd0,
        OP_LOAD_B0   = 3'd1,
        OP_LOAD_B1   = 3'd2,
        OP_LOAD_INIT = 3'd3,
        OP_SEL_B0    = 3'd4,
        OP_SEL_B1    = 3'd5,
        OP_NOP       = 3'd6
    } host_op_e;

    // setup word layout: bit 0 format, bit 1 mode, bits 3:2 rounding
    typedef struct packed {
        logic [1:0] round;
        logic       mode;
        logic       fmt;
    } setup_t;

endpackage

// File: rtl/cbc_strobe_sync.sv
`timescale 1ns/1ps
module cbc_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic wr_pulse
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], strobe_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // rising edge of the synchronized strobe
    assign wr_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/cbc_addr_decode.sv
`timescale 1ns/1ps
module cbc_addr_decode
    import cbc_pkg::*;
(
    input  logic [2:0] addr,
    output host_op_e   op
);
    always_comb begin
        unique case (addr)
            3'b010:  op = OP_LOAD_B0;
            3'b011:  op = OP_LOAD_B1;
            3'b100:  op = OP_LOAD_INIT;
            3'b101:  op = OP_SEL_B0;
            3'b110:  op = OP_SEL_B1;
            3'b111:  op = OP_NOP;
            default: op = OP_RSVD;
        endcase
    end
endmodule

// File: rtl/cbc_bank.sv
`timescale 1ns/1ps
module cbc_bank #(
    parameter int TAPS = 9,
    parameter int DW   = 8,
    parameter int IDXW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               restart,
    input  logic [DW-1:0]      wr_data,
    output logic [TAPS*DW-1:0] coefs,
    output logic [IDXW-1:0]    idx
);
    typedef struct packed {
        logic [IDXW-1:0]          idx;
        logic [TAPS-1:0][DW-1:0]  coef;
    } bank_t;

    bank_t st_d, st_q;
    logic [IDXW-1:0] start;

    always_comb begin
        st_d  = st_q;
        start = restart ? '0 : st_q.idx;
        if (wr_en) begin
            st_d.idx = start;
            for (int k = 0; k < TAPS; k++) begin
                if (start == IDXW'(k)) begin
                    st_d.coef[k] = wr_data;
                    st_d.idx     = IDXW'(k + 1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign coefs = st_q.coef;
    assign idx   = st_q.idx;
endmodule

// File: rtl/coef_bank_ctrl.sv
`timescale 1ns/1ps
module coef_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int TAPS        = 9,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         host_addr,
    input  logic [DW-1:0]      host_data,
    input  logic               host_ld,
    output logic [TAPS*DW-1:0] coef_active,
    output logic               active_bank,
    output logic               fmt_signed,
    output logic               mode_2d,
    output logic [1:0]         round_sel
);
    localparam int IDX_W  = $clog2(TAPS + 1);
    localparam int NBANKS = 2;

    typedef struct packed {
        host_op_e last_op;
        logic     active;
        setup_t   setup;
    } ctrl_t;

    ctrl_t    ctl_d, ctl_q;
    logic     wr_pulse;
    host_op_e op;

    logic [TAPS*DW-1:0]      bank_coefs [NBANKS];
    logic [NBANKS*IDX_W-1:0] bank_idx;

    cbc_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_async (host_ld),
        .wr_pulse     (wr_pulse)
    );

    cbc_addr_decode u_dec (
        .addr (host_addr),
        .op   (op)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        localparam host_op_e LOAD_OP = (b == 0) ? OP_LOAD_B0 : OP_LOAD_B1;
        cbc_bank #(.TAPS(TAPS), .DW(DW), .IDXW(IDX_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_pulse && (op == LOAD_OP)),
            .restart (ctl_q.last_op != LOAD_OP),
            .wr_data (host_data),
            .coefs   (bank_coefs[b]),
            .idx     (bank_idx[b*IDX_W +: IDX_W])
        );
    end

    always_comb begin
        ctl_d = ctl_q;
        if (wr_pulse) begin
            ctl_d.last_op = op;
            case (op)
                OP_LOAD_INIT: ctl_d.setup  = setup_t'(host_data[3:0]);
                OP_SEL_B0:    ctl_d.active = 1'b0;
                OP_SEL_B1:    ctl_d.active = 1'b1;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{last_op: OP_NOP, active: 1'b0, setup: '0};
        else        ctl_q <= ctl_d;
    end

    assign coef_active = ctl_q.active ? bank_coefs[1] : bank_coefs[0];
    assign active_bank = ctl_q.active;
    assign fmt_signed  = ctl_q.setup.fmt;
    assign mode_2d     = ctl_q.setup.mode;
    assign round_sel   = ctl_q.setup.round;
endmodule

// File: rtl/cbc_checker.sv
`timescale 1ns/1ps
module cbc_checker #(
    parameter int TAPS = 9,
    parameter int IDXW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_pulse,
    input logic [2:0]      host_addr,
    input logic            active_bank,
    input logic            fmt_signed,
    input logic            mode_2d,
    input logic [1:0]      round_sel,
    input logic [2*IDXW-1:0] bank_idx
);
    assert_reset_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (active_bank == 1'b0));

    assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_idx[IDXW-1:0] <= IDXW'(TAPS)) && (bank_idx[2*IDXW-1:IDXW] <= IDXW'(TAPS)));

    assert_sel_b1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && host_addr == 3'b110) |=> (active_bank == 1'b1));

    assert_sel_b0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && host_addr == 3'b101) |=> (active_bank == 1'b0));

    assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pulse && host_addr[2] && host_addr != 3'b100) |=> $stable(active_bank));

    assert_setup_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pulse && host_addr == 3'b100) |=> ($stable(fmt_signed) && $stable(mode_2d) && $stable(round_sel)));

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);
endmodule

bind coef_bank_ctrl cbc_checker #(.TAPS(TAPS), .IDXW(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_pulse    (wr_pulse),
    .host_addr   (host_addr),
    .active_bank (active_bank),
    .fmt_signed  (fmt_signed),
    .mode_2d     (mode_2d),
    .round_sel   (round_sel),
    .bank_idx    (bank_idx)
);

// File: tb/coef_bank_ctrl_bench.sv
`timescale 1ns/1ps
module coef_bank_ctrl_bench;
    localparam int TAPS = 9;
    localparam int DW   = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [2:0]         host_addr = 3'b111;
    logic [DW-1:0]      host_data = '0;
    logic               host_ld = 1'b0;
    logic [TAPS*DW-1:0] coef_active;
    logic               active_bank, fmt_signed, mode_2d;
    logic [1:0]         round_sel;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // expected state, kept from the requirements
    logic [DW-1:0] m_coef [2][TAPS];
    int            m_idx [2];
    logic [2:0]    m_last;
    logic          m_active;
    logic [3:0]    m_setup;

    always #2 clk = ~clk;

    coef_bank_ctrl u_coef_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_data(host_data),
        .host_ld(host_ld), .coef_active(coef_active), .active_bank(active_bank),
        .fmt_signed(fmt_signed), .mode_2d(mode_2d), .round_sel(round_sel)
    );

    function automatic logic [TAPS*DW-1:0] packed_bank(input int b);
        logic [TAPS*DW-1:0] v;
        for (int k = 0; k < TAPS; k++) v[k*DW +: DW] = m_coef[b][k];
        return v;
    endfunction

    task automatic chk(input string req, input logic [TAPS*DW-1:0] act, input logic [TAPS*DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, coef_active, packed_bank(m_active ? 1 : 0));
        chk(req, {71'd0, active_bank}, {71'd0, m_active});
        chk(req, {68'd0, round_sel, mode_2d, fmt_signed}, {68'd0, m_setup});
    endtask

    task automatic model(input logic [2:0] a, input logic [DW-1:0] d);
        if (a == 3'b010 || a == 3'b011) begin
            int b = (a == 3'b011) ? 1 : 0;
            if (m_last != a) m_idx[b] = 0;
            if (m_idx[b] < TAPS) begin
                m_coef[b][m_idx[b]] = d;
                m_idx[b]++;
            end
        end else if (a == 3'b100) m_setup = d[3:0];
        else if (a == 3'b101) m_active = 1'b0;
        else if (a == 3'b110) m_active = 1'b1;
        m_last = a;
    endtask

    task automatic host_write(input logic [2:0] a, input logic [DW-1:0] d, input int hold = 4);
        @(negedge clk);
        host_addr = a; host_data = d; host_ld = 1'b1;
        repeat (hold) @(negedge clk);
        host_ld = 1'b0;
        repeat (4) @(negedge clk);
        model(a, d);
    endtask

    task automatic t_reset;
        for (int b = 0; b < 2; b++) begin
            m_idx[b] = 0;
            for (int k = 0; k < TAPS; k++) m_coef[b][k] = '0;
        end
        m_last = 3'b111; m_active = 1'b0; m_setup = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 reset state");
    endtask

    task automatic t_load_bank0;
        for (int k = 0; k < TAPS; k++) host_write(3'b010, 8'h10 + 8'(k * 7));
        chk_all("R2 bank0 sequential load");
    endtask

    task automatic t_setup;
        host_write(3'b100, 8'hFB);
        chk_all("R5 setup 0xB");
        host_write(3'b100, 8'h04);
        chk_all("R5 setup 0x4");
    endtask

    task automatic t_fill_idle_bank;
        for (int k = 0; k < TAPS; k++) host_write(3'b011, 8'hA0 ^ 8'(k * 13));
        chk_all("R10 idle bank fill");
        host_write(3'b011, 8'h5A);
        chk_all("R4 tenth write to bank1");
        host_write(3'b110, 8'h00);
        chk_all("R6 select bank1");
        chk("R2 bank1 contents", coef_active, packed_bank(1));
        chk("R4 bank1 slot I kept", {64'd0, coef_active[8*DW +: DW]}, {64'd0, 8'hA0 ^ 8'd104});
        host_write(3'b010, 8'h77);
        chk_all("R10 write bank0 while bank1 active");
        host_write(3'b101, 8'h00);
        chk_all("R6 select bank0");
    endtask

    task automatic t_restart;
        host_write(3'b111, 8'h00);
        host_write(3'b010, 8'hC1);
        host_write(3'b010, 8'hC2);
        host_write(3'b010, 8'hC3);
        host_write(3'b111, 8'h00);
        host_write(3'b010, 8'hD9);
        chk_all("R3 restart after nop");
        chk("R3 slot A", {64'd0, coef_active[0 +: DW]}, {64'd0, 8'hD9});
        chk("R3 slot B kept", {64'd0, coef_active[DW +: DW]}, {64'd0, 8'hC2});
        host_write(3'b000, 8'h00);
        host_write(3'b010, 8'hE4);
        chk("R3 restart after reserved", {64'd0, coef_active[0 +: DW]}, {64'd0, 8'hE4});
    endtask

    task automatic t_reserved;
        host_write(3'b000, 8'hFF);
        chk_all("R7 address 000");
        host_write(3'b001, 8'hFF);
        chk_all("R7 address 001");
        host_write(3'b111, 8'hFF);
        chk_all("R7 address 111");
    endtask

    task automatic t_long_strobe;
        host_write(3'b111, 8'h00);
        host_write(3'b010, 8'h31, 20);
        host_write(3'b010, 8'h32);
        chk_all("R8 long strobe single write");
        chk("R8 slot B", {64'd0, coef_active[DW +: DW]}, {64'd0, 8'h32});
    endtask

    task automatic t_latency;
        @(negedge clk);
        host_addr = 3'b110; host_data = 8'h00; host_ld = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk("R9 unchanged after second edge", {71'd0, active_bank}, {71'd0, 1'b0});
        @(posedge clk); #1;
        chk("R9 switched after third edge", {71'd0, active_bank}, {71'd0, 1'b1});
        chk("R9 coefficients switch same edge", coef_active, packed_bank(1));
        @(negedge clk);
        host_ld = 1'b0;
        repeat (4) @(negedge clk);
        model(3'b110, 8'h00);
        chk_all("R9 settled");
    endtask

    initial begin
        t_reset();
        t_load_bank0();
        t_setup();
        t_fill_idle_bank();
        t_restart();
        t_reserved();
        t_long_strobe();
        t_latency();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule